// File: doc/BRIEF.md
# Prefix-Driven Vector Loop Issuer

This block sits between instruction decode and issue and turns a prefixed scalar instruction into a sequence of element-level scalar micro-ops. Each fetched 64-bit pair is examined. When the upper word is a vectorisation prefix, the lower word is an ordinary scalar instruction. That suffix is re-issued once per element, with a rising element index, while the program counter stays put. The program counter moves past the whole 8-byte pair only when the loop for that instruction has finished. A word without a prefix is issued once as a plain scalar micro-op and advances the program counter by 4.

Two loop styles are supported, chosen per instruction by the `vf_mode` input:
- **Horizontal-first:** every element from 0 to VL-1 is issued back to back before the program counter advances.
- **Vertical-first:** each pass issues a single element at a persistent index. The index moves on, and the program counter advances, only when an explicit step request arrives.

The vector length (VL) lives in a local register. A set-vector-length strobe writes it.

The controller has six states:
- `ST_FETCH`: waits for an instruction.
- `ST_SCALAR`: issues one unprefixed micro-op.
- `ST_HORIZ`: runs the horizontal-first loop.
- `ST_VERT`: issues the single vertical-first element.
- `ST_STEP`: waits for the step request.
- `ST_ADV`: pulses the program-counter advance for one cycle.

Transitions:
- `ST_FETCH` goes to `ST_SCALAR`, `ST_HORIZ`, `ST_VERT` or `ST_ADV` (prefixed with VL = 0) when an instruction is accepted.
- `ST_SCALAR` goes to `ST_ADV` on acceptance of its micro-op.
- `ST_HORIZ` goes to `ST_ADV` when the last element is accepted.
- `ST_VERT` goes to `ST_STEP` when its element is accepted.
- `ST_STEP` goes to `ST_ADV` on a step request.
- `ST_ADV` always returns to `ST_FETCH`.

Top module: `vec_loop_issuer`

## Requirements
- R1: The upper word is a prefix exactly when its bits [31:26] equal 6'd1, bit [25] is 1 and bit [22] is 1 (bit 0 is the least significant). Any other upper word, including one with bits [31:26] = 6'd1 but bit [22] = 0, is handled as an unprefixed scalar instruction.
- R2: An unprefixed instruction issues exactly one micro-op. That micro-op carries `uop_insn` = upper word, `uop_elem` = 0, `uop_scalar` = 1 and `uop_ctx` = 0. It is followed by one `pc_adv` pulse with `pc_step` = 4.
- R3: Every micro-op of a prefixed instruction carries the lower word unchanged in `uop_insn`, `uop_scalar` = 0, and the 24-bit context `uop_ctx` = {upper[24:23], upper[21:0]}.
- R4: In horizontal-first mode (`vf_mode` = 0 at acceptance), the elements 0, 1, …, VL-1 are issued in order, starting from 0 for every instruction. `pc_adv` with `pc_step` = 8 comes in the cycle after the last element is accepted, and never earlier.
- R5: A prefixed instruction accepted while VL = 0 issues no micro-op, and `pc_adv` with `pc_step` = 8 comes in the cycle right after acceptance.
- R6: In vertical-first mode (`vf_mode` = 1), each pass issues exactly one micro-op at the persistent index. `pc_adv` stays low until `step_req` is seen. The step moves the index to index+1, or to 0 when index+1 reaches VL, and is followed by `pc_adv` with `pc_step` = 8.
- R7: If the persistent vertical-first index is not below VL when a vertical-first instruction is accepted, that pass issues index 0.
- R8: A `vl_we` strobe loads `vl_wdata` into VL, saturating at VL_MAX (64 by default). VL is 0 after reset and is unchanged without a strobe.
- R9: While `uop_valid` is 1 and `uop_ready` is 0, the micro-op (`uop_insn`, `uop_elem`, `uop_ctx`, `uop_scalar`) is held stable and stays valid.
- R10: `in_ready` is 1 only while no instruction is in progress. It is 0 from acceptance until after the `pc_adv` pulse, so each instruction yields exactly one `pc_adv`.
- R11: After reset, `in_ready` is 1 and `uop_valid` and `pc_adv` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Fetched pair is present |
| in_ready | output | 1 | Block accepts a new pair |
| in_hi | input | 32 | Upper word (prefix or scalar instruction) |
| in_lo | input | 32 | Lower word (suffix when prefixed) |
| vf_mode | input | 1 | 1 selects vertical-first for this instruction |
| vl_we | input | 1 | Set-vector-length update strobe |
| vl_wdata | input | VLW (7) | New vector length |
| step_req | input | 1 | Vertical-first step request |
| uop_valid | output | 1 | Micro-op present |
| uop_ready | input | 1 | Issue accepts the micro-op |
| uop_insn | output | 32 | Scalar instruction for this element |
| uop_ctx | output | 24 | Vectorisation context of the prefix |
| uop_elem | output | IW (6) | Element index |
| uop_scalar | output | 1 | Micro-op comes from an unprefixed instruction |
| pc_adv | output | 1 | Program counter advance pulse |
| pc_step | output | 4 | Bytes to advance (4 or 8) while `pc_adv` is 1, else 0 |

## Verification
The embedded assertions rely on these conditions from the surrounding logic:
- Issue may drop `uop_ready` at any cycle.
- `step_req` matters only while the block waits in `ST_STEP`.
- `vl_we` is not pulsed while an instruction is in progress, so VL stays constant during one loop.

The directed stimulus respects all three. Every VL write is made while `in_ready` is 1. The step request is pulsed only after the vertical-first element has been accepted. Every input is driven on the falling edge, so no input changes near the sampling edge.

// File: rtl/vli_pkg.sv
package vli_pkg;

    typedef enum logic [2:0] {
        ST_FETCH  = 3'd0,
        ST_SCALAR = 3'd1,
        ST_HORIZ  = 3'd2,
        ST_VERT   = 3'd3,
        ST_STEP   = 3'd4,
        ST_ADV    = 3'd5
    } vli_state_e;

    localparam int CTX_W      = 24;
    localparam int INSN_W     = 32;
    localparam int STEP_W     = 4;
    localparam logic [5:0] PFX_MAJOR = 6'd1;

endpackage

// File: rtl/vli_prefix_decode.sv
module vli_prefix_decode
    import vli_pkg::*;
(
    input  logic [INSN_W-1:0] word,
    output logic              is_pfx,
    output logic [CTX_W-1:0]  ctx
);

    // major opcode in the top six bits, two marker bits must both be set
    always_comb begin
        is_pfx = (word[31:26] == PFX_MAJOR) && word[25] && word[22];
        ctx    = {word[24:23], word[21:0]};
    end

endmodule

// File: rtl/vli_vl_reg.sv
module vli_vl_reg #(
    parameter int VL_MAX = 64,
    parameter int VLW    = $clog2(VL_MAX + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [VLW-1:0] wdata,
    output logic [VLW-1:0] vl
);

    localparam logic [VLW-1:0] VL_CAP = VLW'(VL_MAX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vl <= '0;
        end else if (we) begin
            vl <= (wdata > VL_CAP) ? VL_CAP : wdata;
        end
    end

    assert_vl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(vl));

    assert_vl_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vl <= VL_CAP);

endmodule

// File: rtl/vec_loop_issuer.sv
module vec_loop_issuer
    import vli_pkg::*;
#(
    parameter int VL_MAX = 64,
    parameter int VLW    = $clog2(VL_MAX + 1),
    parameter int IW     = $clog2(VL_MAX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [31:0]       in_hi,
    input  logic [31:0]       in_lo,
    input  logic              vf_mode,
    input  logic              vl_we,
    input  logic [VLW-1:0]    vl_wdata,
    input  logic              step_req,
    output logic              uop_valid,
    input  logic              uop_ready,
    output logic [31:0]       uop_insn,
    output logic [23:0]       uop_ctx,
    output logic [IW-1:0]     uop_elem,
    output logic              uop_scalar,
    output logic              pc_adv,
    output logic [3:0]        pc_step
);

    vli_state_e          state_q, state_d;
    logic [VLW-1:0]      vl;
    logic                dec_pfx;
    logic [CTX_W-1:0]    dec_ctx;
    logic [INSN_W-1:0]   insn_q;
    logic [CTX_W-1:0]    ctx_q;
    logic                pfx_q;
    logic [IW-1:0]       elem_q;
    logic [IW-1:0]       vf_idx_q;
    logic [VLW-1:0]      elem_nx;
    logic [VLW-1:0]      vf_nx;
    logic                elem_last;
    logic                accept;

    vli_prefix_decode u_dec (
        .word   (in_hi),
        .is_pfx (dec_pfx),
        .ctx    (dec_ctx)
    );

    vli_vl_reg #(.VL_MAX(VL_MAX), .VLW(VLW)) u_vl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (vl_we),
        .wdata (vl_wdata),
        .vl    (vl)
    );

    assign accept    = in_valid && (state_q == ST_FETCH);
    assign elem_nx   = VLW'(elem_q) + VLW'(1);
    assign vf_nx     = VLW'(vf_idx_q) + VLW'(1);
    assign elem_last = (elem_nx >= vl);

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH: begin
                if (in_valid) begin
                    if (!dec_pfx)         state_d = ST_SCALAR;
                    else if (vl == '0)    state_d = ST_ADV;
                    else if (vf_mode)     state_d = ST_VERT;
                    else                  state_d = ST_HORIZ;
                end
            end
            ST_SCALAR: if (uop_ready) state_d = ST_ADV;
            ST_HORIZ:  if (uop_ready && elem_last) state_d = ST_ADV;
            ST_VERT:   if (uop_ready) state_d = ST_STEP;
            ST_STEP:   if (step_req) state_d = ST_ADV;
            ST_ADV:    state_d = ST_FETCH;
            default:   state_d = ST_FETCH;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= state_d;
    end

    // captured instruction and element counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            insn_q   <= '0;
            ctx_q    <= '0;
            pfx_q    <= 1'b0;
            elem_q   <= '0;
            vf_idx_q <= '0;
        end else begin
            if (accept) begin
                insn_q <= dec_pfx ? in_lo : in_hi;
                ctx_q  <= dec_pfx ? dec_ctx : '0;
                pfx_q  <= dec_pfx;
                elem_q <= '0;
                if (dec_pfx && vf_mode && (vl != '0) && (VLW'(vf_idx_q) >= vl))
                    vf_idx_q <= '0;
            end
            if (state_q == ST_HORIZ && uop_ready && !elem_last)
                elem_q <= elem_q + IW'(1);
            if (state_q == ST_STEP && step_req)
                vf_idx_q <= (vf_nx >= vl) ? '0 : IW'(vf_nx);
        end
    end

    // outputs
    always_comb begin
        in_ready   = 1'b0;
        uop_valid  = 1'b0;
        uop_elem   = '0;
        uop_scalar = 1'b0;
        pc_adv     = 1'b0;
        pc_step    = '0;
        uop_insn   = insn_q;
        uop_ctx    = ctx_q;
        unique case (state_q)
            ST_FETCH:  in_ready = 1'b1;
            ST_SCALAR: begin
                uop_valid  = 1'b1;
                uop_scalar = 1'b1;
            end
            ST_HORIZ: begin
                uop_valid = 1'b1;
                uop_elem  = elem_q;
            end
            ST_VERT: begin
                uop_valid = 1'b1;
                uop_elem  = vf_idx_q;
            end
            ST_STEP: ;
            ST_ADV: begin
                pc_adv  = 1'b1;
                pc_step = pfx_q ? 4'd8 : 4'd4;
            end
            default: ;
        endcase
    end

    // checks next to the logic they guard
    assert_uop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && !uop_ready) |=> (uop_valid && $stable(uop_elem)
            && $stable(uop_insn) && $stable(uop_ctx) && $stable(uop_scalar)));

    assert_elem_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_ready && !uop_scalar && !pc_adv && state_q == ST_HORIZ
            && state_d == ST_HORIZ) |=> (uop_elem == $past(uop_elem) + IW'(1)));

    assert_scalar_elem_R2: assert property (@(posedge clk) disable iff (!rst_n)
        uop_scalar |-> (uop_valid && uop_elem == '0 && uop_ctx == '0));

    assert_pc_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pc_adv |-> ((pc_step == 4'd4 || pc_step == 4'd8) && !uop_valid && !in_ready));

    assert_fetch_after_adv_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pc_adv |=> (in_ready && !pc_adv));

    assert_step_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP && !step_req) |=> !pc_adv);

endmodule

// File: tb/vec_loop_issuer_tb.sv
`timescale 1ns/1ps
module vec_loop_issuer_tb;

    localparam int VL_MAX = 64;
    localparam int VLW    = 7;
    localparam int IW     = 6;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            in_valid;
    logic            in_ready;
    logic [31:0]     in_hi, in_lo;
    logic            vf_mode;
    logic            vl_we;
    logic [VLW-1:0]  vl_wdata;
    logic            step_req;
    logic            uop_valid;
    logic            uop_ready;
    logic [31:0]     uop_insn;
    logic [23:0]     uop_ctx;
    logic [IW-1:0]   uop_elem;
    logic            uop_scalar;
    logic            pc_adv;
    logic [3:0]      pc_step;

    int n_chk = 0;
    int n_fail = 0;
    int exp_vf = 0;
    int cur_vl = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    vec_loop_issuer #(.VL_MAX(VL_MAX)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_hi(in_hi), .in_lo(in_lo), .vf_mode(vf_mode), .vl_we(vl_we),
        .vl_wdata(vl_wdata), .step_req(step_req), .uop_valid(uop_valid),
        .uop_ready(uop_ready), .uop_insn(uop_insn), .uop_ctx(uop_ctx),
        .uop_elem(uop_elem), .uop_scalar(uop_scalar), .pc_adv(pc_adv),
        .pc_step(pc_step)
    );

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [23:0] ctx_of(input logic [31:0] w);
        return {w[24:23], w[21:0]};
    endfunction

    // all tasks start and end on a falling edge
    task automatic set_vl(input int v);
        vl_we = 1'b1;
        vl_wdata = VLW'(v);
        @(negedge clk);
        vl_we = 1'b0;
        cur_vl = (v > VL_MAX) ? VL_MAX : v;
    endtask

    task automatic send(input string tag, input logic [31:0] hi, input logic [31:0] lo, input logic vf);
        in_hi = hi; in_lo = lo; vf_mode = vf; in_valid = 1'b1;
        chk(tag, "in_ready before accept", in_ready, 1);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic collect(input string tag, input logic [31:0] e_insn, input logic [23:0] e_ctx,
                           input logic e_sc, input int cnt, input int e_step);
        int n = 0;
        int cyc = 0;
        int adv_at = -1;
        uop_ready = 1'b1;
        chk(tag, "in_ready low while busy", in_ready, 0);
        while (adv_at < 0 && cyc < 300) begin
            if (uop_valid) begin
                chk(tag, "elem", uop_elem, n);
                chk(tag, "insn", uop_insn, e_insn);
                chk(tag, "ctx", uop_ctx, e_ctx);
                chk(tag, "scalar", uop_scalar, e_sc);
                n++;
            end
            if (pc_adv) begin
                chk(tag, "pc_step", pc_step, e_step);
                adv_at = cyc;
            end
            @(negedge clk);
            cyc++;
        end
        chk(tag, "uop count", n, cnt);
        chk(tag, "pc_adv cycle", adv_at, cnt);
    endtask

    task automatic vf_pass(input string tag, input logic [31:0] hi, input logic [31:0] lo);
        uop_ready = 1'b1;
        send(tag, hi, lo, 1'b1);
        if (exp_vf >= cur_vl) exp_vf = 0;
        chk(tag, "vf uop valid", uop_valid, 1);
        chk(tag, "vf elem", uop_elem, exp_vf);
        chk(tag, "vf insn", uop_insn, lo);
        @(negedge clk);
        chk(tag, "single uop", uop_valid, 0);
        chk(tag, "no pc_adv before step", pc_adv, 0);
        @(negedge clk);
        chk(tag, "still waiting", pc_adv, 0);
        step_req = 1'b1;
        @(negedge clk);
        step_req = 1'b0;
        chk(tag, "pc_adv after step", pc_adv, 1);
        chk(tag, "vf pc_step", pc_step, 8);
        exp_vf = (exp_vf + 1 >= cur_vl) ? 0 : exp_vf + 1;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R11", "in_ready", in_ready, 1);
        chk("R11", "uop_valid", uop_valid, 0);
        chk("R11", "pc_adv", pc_adv, 0);
    endtask

    task automatic t_scalar;
        send("R2", 32'h3860_0005, 32'hDEAD_BEEF, 1'b0);
        collect("R2", 32'h3860_0005, 24'h0, 1'b1, 1, 4);
        // major opcode 1 but bit 22 clear: not a prefix
        send("R1", 32'h0600_1111, 32'hDEAD_BEEF, 1'b0);
        collect("R1", 32'h0600_1111, 24'h0, 1'b1, 1, 4);
    endtask

    task automatic t_horiz;
        logic [31:0] p1 = 32'h06C0_ABCD;
        logic [31:0] p2 = 32'h0778_0042;
        set_vl(5);
        send("R4", p1, 32'h7C22_1A14, 1'b0);
        collect("R3", 32'h7C22_1A14, ctx_of(p1), 1'b0, 5, 8);
        send("R4", p2, 32'h3863_0001, 1'b0);
        collect("R4", 32'h3863_0001, ctx_of(p2), 1'b0, 5, 8);
    endtask

    task automatic t_hold;
        logic [31:0] p = 32'h0640_0007;
        set_vl(3);
        uop_ready = 1'b0;
        send("R9", p, 32'h1234_5678, 1'b0);
        for (int i = 0; i < 3; i++) begin
            chk("R9", "held valid", uop_valid, 1);
            chk("R9", "held elem", uop_elem, 0);
            chk("R9", "held insn", uop_insn, 32'h1234_5678);
            chk("R9", "no pc_adv", pc_adv, 0);
            @(negedge clk);
        end
        collect("R9", 32'h1234_5678, ctx_of(p), 1'b0, 3, 8);
    endtask

    task automatic t_vl_zero;
        set_vl(0);
        send("R5", 32'h0640_0001, 32'h1111_2222, 1'b0);
        collect("R5", 32'h1111_2222, ctx_of(32'h0640_0001), 1'b0, 0, 8);
    endtask

    task automatic t_saturate;
        set_vl(100);
        send("R8", 32'h0640_0003, 32'h3860_0009, 1'b0);
        collect("R8", 32'h3860_0009, ctx_of(32'h0640_0003), 1'b0, VL_MAX, 8);
    endtask

    task automatic t_vertical;
        set_vl(3);
        for (int i = 0; i < 4; i++) vf_pass("R6", 32'h0640_0100, 32'h3860_0010);
        chk("R6", "index wrapped", exp_vf, 1);
        set_vl(4);
        vf_pass("R6", 32'h0640_0100, 32'h3860_0011);
        vf_pass("R6", 32'h0640_0100, 32'h3860_0012);
        set_vl(2);
        vf_pass("R7", 32'h0640_0100, 32'h3860_0013);
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_hi = '0; in_lo = '0; vf_mode = 1'b0;
        vl_we = 1'b0; vl_wdata = '0; step_req = 1'b0; uop_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_scalar();
        t_horiz();
        t_hold();
        t_vl_zero();
        t_saturate();
        t_vertical();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule